// File: doc/BRIEF.md
# Edge-Restarted Manchester and Pulse-Width Bit Demodulator

This block turns a serial line carrying Manchester or pulse-width coded data into bytes. It does not oversample the line with a free-running clock. A counter runs at the system clock rate and is cleared by each qualifying line transition. The bit is taken when the counter reaches a first programmable value, `cmp1`. The level of the line at that moment is the decoded bit. It is shifted most significant bit first into an 8-bit register. A second programmable value, `cmp2`, bounds how long the block waits for the next transition. If it is reached, the block reports a timing error.

In Manchester mode every transition of the line qualifies. Transitions that arrive before the sample point are ignored; these are the bit-boundary transitions. In pulse-width mode only rising transitions qualify. The sampled level then tells a long high pulse (1) from a short one (0).

Decoding begins only after a hunting phase. While hunting, the block waits for a qualifying transition that follows the previous one (or reset) by more than `cmp1` counts. That transition starts the first bit. For Manchester data, `cmp1` is set between one half and one full bit time, so only a full-bit gap arms the decoder. `cmp2` must be larger than `cmp1`.

Top module: `manch_demod`

## Requirements
- R1: After reset, `byte_out` is 0, and `byte_vld` and `err` are low.
- R2: With `pw_mode`=0, both rising and falling transitions of `ser_in` qualify. The decoded bit is the line level `cmp1`+1 clocks after the restarting transition.
- R3: With `pw_mode`=1, only rising transitions qualify. A falling transition never restarts the counter. A high pulse still present at the sample point decodes as 1, and one already ended decodes as 0.
- R4: While hunting, each qualifying transition restarts the counter. Decoding is armed only when the counter exceeds `cmp1` at that transition. Transitions spaced `cmp1`+1 clocks apart never arm the decoder; a spacing of `cmp1`+2 clocks does.
- R5: After a restart, qualifying transitions that arrive before the counter equals `cmp1` have no effect. When the counter equals `cmp1`, one bit is sampled.
- R6: After a bit is sampled, the next qualifying transition restarts the counter for the following bit.
- R7: Bits enter most significant bit first. After the eighth bit, `byte_out` holds the byte and `byte_vld` is high for exactly one clock.
- R8: If the counter reaches `cmp2` after a sample with no qualifying transition, `err` pulses for one clock. The block returns to hunting and drops the partial byte, so the next frame decodes from an empty register.
- R9: A qualifying transition in the same cycle as the `cmp2` match restarts the bit and raises no error. Restart spacing of `cmp2`+1 clocks is legal; `cmp2`+2 clocks is an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bit counter advances once per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Asynchronous coded serial line |
| pw_mode | input | 1 | 0 = Manchester (both transitions), 1 = pulse-width (rising only) |
| cmp1 | input | 8 | Sample point and hunting threshold, in clocks after a restart |
| cmp2 | input | 8 | Timeout limit, in clocks after a restart; must exceed cmp1 |
| byte_out | output | 8 | Last completed byte |
| byte_vld | output | 1 | One-cycle strobe when byte_out is updated |
| err | output | 1 | One-cycle timing error pulse |

## Verification
Two functions can fall in the same cycle: the timeout match on `cmp2` and the arrival of the next qualifying transition. The bench provokes this in pulse-width mode by placing the second rising transition exactly `cmp2`+1 clocks after the first. It then repeats the test one clock later. The two outcomes are told apart by counting error pulses: one pulse (the end-of-frame timeout) means the transition won, and two pulses mean the timeout fired first and a fresh hunt followed. The same counting method checks the arming threshold one clock either side of `cmp1`.

// File: rtl/md_pkg.sv
// Shared types for the Manchester / pulse-width demodulator.
// Assumes: nothing; holds only the sequencer state encoding.
package md_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,  // waiting for a long gap to align on
        ST_ARMED   = 2'd1,  // counting towards the sample point
        ST_LATCHED = 2'd2   // bit taken, waiting for the realigning transition
    } md_state_t;
endpackage

// File: rtl/md_edge_det.sv
// Line synchronizer and transition detector.
// Assumes: din is asynchronous; rise_only is quasi-static.
// Produces the synchronized level and a one-cycle pulse per qualifying transition.
module md_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_only,
    output logic lvl,
    output logic edge_p
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain, one flop per stage
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // First stage captures the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= din;
            end
        end else begin : g_rest
            // Later stages pass the level along
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // Delayed copy of the level for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    logic rise_w, fall_w;
    // Qualify transitions according to the mode
    always_comb begin
        rise_w = lvl & ~prev_q;
        fall_w = ~lvl & prev_q;
        edge_p = rise_w | (fall_w & ~rise_only);
    end

    // R3
    pw_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_only && edge_p) |-> (lvl && !prev_q));
endmodule

// File: rtl/md_bit_timer.sv
// Saturating up-counter that is cleared on request.
// Assumes: one increment per clock; it holds at all-ones until restarted.
module md_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up, clear on restart, stop at the top
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/md_seq_ctrl.sv
// Bit sequencer: hunts for alignment, picks the sample point, detects timeouts.
// Assumes: cmp2 > cmp1; edge_p is already qualified for the mode.
module md_seq_ctrl
    import md_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_p,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    output logic             restart,
    output logic             shift_en,
    output logic             abort,
    output logic             err
);
    md_state_t state_q, state_d;
    logic      past1, hit1, hit2;

    // Next-state and strobe decode
    always_comb begin
        past1    = cnt > cmp1;
        hit1     = cnt == cmp1;
        hit2     = cnt == cmp2;
        state_d  = state_q;
        restart  = 1'b0;
        shift_en = 1'b0;
        abort    = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                restart = edge_p;
                if (edge_p && past1) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit1) begin
                    shift_en = 1'b1;
                    state_d  = ST_LATCHED;
                end else if (hit2) begin
                    abort   = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            ST_LATCHED: begin
                if (edge_p) begin
                    restart = 1'b1;
                    state_d = ST_ARMED;
                end else if (hit2) begin
                    abort   = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register and registered error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            err     <= abort;
        end
    end

    // R8
    err_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (state_q == ST_HUNT));
    // R4
    hunt_noshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> !shift_en);
    // R8
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

// File: rtl/md_byte_asm.sv
// Serial-to-parallel assembler: MSB first, emits a byte with a one-cycle strobe.
// Assumes: shift_en and clear never coincide.
module md_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              clear,
    output logic [BYTE_W-1:0] data,
    output logic              vld
);
    localparam int              BC_W     = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] BC_LAST  = BC_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sr_q;
    logic [BC_W-1:0]   bcnt_q;
    logic [BYTE_W-1:0] sr_next;

    // Shift value with the new bit at the bottom
    always_comb sr_next = {sr_q[BYTE_W-2:0], bit_in};

    // Shift register, bit counter and byte hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bcnt_q <= '0;
            data   <= '0;
            vld    <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (clear) begin
                sr_q   <= '0;
                bcnt_q <= '0;
            end else if (shift_en) begin
                sr_q <= sr_next;
                if (bcnt_q == BC_LAST) begin
                    data   <= sr_next;
                    vld    <= 1'b1;
                    bcnt_q <= '0;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end
    end

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bcnt_q == '0 && !vld));
endmodule

// File: rtl/manch_demod.sv
// Top level of the edge-restarted Manchester / pulse-width demodulator.
// Assumes: cmp2 > cmp1, both stable while a frame is received.
module manch_demod #(
    parameter int CNT_W       = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              pw_mode,
    input  logic [CNT_W-1:0]  cmp1,
    input  logic [CNT_W-1:0]  cmp2,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              err
);
    logic             lvl, edge_p, restart, shift_en, abort;
    logic [CNT_W-1:0] cnt;

    md_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(ser_in), .rise_only(pw_mode),
        .lvl(lvl), .edge_p(edge_p)
    );

    md_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cnt(cnt)
    );

    md_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .edge_p(edge_p), .cnt(cnt),
        .cmp1(cmp1), .cmp2(cmp2), .restart(restart),
        .shift_en(shift_en), .abort(abort), .err(err)
    );

    md_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(lvl),
        .clear(abort), .data(byte_out), .vld(byte_vld)
    );
endmodule

// File: tb/manch_demod_tb_top.sv
// Bench for manch_demod: directed corner cases plus seeded random frames.
module manch_demod_tb_top;
    localparam int MH = 16;              // Manchester half-bit, clocks
    localparam int PW_T = 48, PW_S = 8, PW_L = 36;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       pw_mode = 1'b0;
    logic [7:0] cmp1 = 8'd24;
    logic [7:0] cmp2 = 8'd40;
    logic [7:0] byte_out;
    logic       byte_vld, err;

    int n_chk = 0, n_fail = 0, err_cnt = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];

    always #4 clk = ~clk;   // 125 MHz

    manch_demod dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .pw_mode(pw_mode),
        .cmp1(cmp1), .cmp2(cmp2), .byte_out(byte_out),
        .byte_vld(byte_vld), .err(err)
    );

    // Collect outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) rx_q.push_back(byte_out);
            if (err) err_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(5);
        rst_n = 1'b1;
    endtask

    task automatic clear_obs();
        rx_q.delete();
        err_cnt = 0;
    endtask

    // Expected pulse high time for a pulse-width bit
    function automatic int pw_high(input bit b);
        return b ? PW_L : PW_S;
    endfunction

    // One Manchester bit: the first half carries the value
    task automatic man_bit(input bit b);
        ser_in = b;  cyc(MH);
        ser_in = ~b; cyc(MH);
    endtask

    task automatic pw_bit(input bit b);
        ser_in = 1'b1; cyc(pw_high(b));
        ser_in = 1'b0; cyc(PW_T - pw_high(b));
    endtask

    // Send the bytes in tx_q; extra_bits of the next pattern are a truncated tail
    task automatic send_frame(input bit pw, input int extra_bits);
        if (!pw) man_bit(1'b0);   // alignment bit
        foreach (tx_q[k])
            for (int i = 7; i >= 0; i--)
                if (pw) pw_bit(tx_q[k][i]); else man_bit(tx_q[k][i]);
        for (int i = 0; i < extra_bits; i++)
            if (pw) pw_bit(i[0]); else man_bit(i[0]);
        ser_in = 1'b0;
        cyc(150);
    endtask

    task automatic judge_frame(input string req);
        check(rx_q.size() == tx_q.size(), {req, " byte count"}, rx_q.size(), tx_q.size());
        foreach (tx_q[k])
            if (k < rx_q.size())
                check(rx_q[k] == tx_q[k], {req, " byte value"}, rx_q[k], tx_q[k]);
        check(err_cnt == 1, {req, " end timeout"}, err_cnt, 1);
    endtask

    // Rising pulses of 2 clocks with the given spacing
    task automatic pulse_gap(input int gap);
        ser_in = 1'b1; cyc(2);
        ser_in = 1'b0; cyc(gap - 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        cyc(1);
        // R1 reset state
        check(byte_out == 8'h00, "R1 byte_out", byte_out, 0);
        check(byte_vld == 1'b0, "R1 byte_vld", byte_vld, 0);
        check(err == 1'b0, "R1 err", err, 0);
        cyc(100);

        // R2 R5 R6 R7 directed Manchester frame
        clear_obs(); tx_q = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
        send_frame(1'b0, 0); judge_frame("R2/R7 manchester directed");

        // R2 random Manchester frames
        for (int f = 0; f < 4; f++) begin
            clear_obs(); tx_q.delete();
            for (int k = 0; k < 1 + int'($urandom_range(2)); k++) tx_q.push_back(8'($urandom));
            send_frame(1'b0, 0); judge_frame("R2 manchester random");
        end

        // R8 truncated frame: partial byte dropped, next frame clean
        clear_obs(); tx_q = '{8'h81, 8'h7E, 8'hC3};
        send_frame(1'b0, 4);
        judge_frame("R8 truncated");
        clear_obs(); tx_q = '{8'h96};
        send_frame(1'b0, 0); judge_frame("R8 after truncation");

        // R3 pulse-width frames
        pw_mode = 1'b1; cmp1 = 8'd20; cmp2 = 8'd60;
        clear_obs(); tx_q = '{8'h5A, 8'hF0};
        send_frame(1'b1, 0); judge_frame("R3 pulse-width directed");
        for (int f = 0; f < 3; f++) begin
            clear_obs(); tx_q.delete();
            for (int k = 0; k < 1 + int'($urandom_range(2)); k++) tx_q.push_back(8'($urandom));
            send_frame(1'b1, 0); judge_frame("R3 pulse-width random");
        end

        // R9 transition exactly at the cmp2 match wins
        clear_obs();
        pulse_gap(61); pulse_gap(2); ser_in = 1'b0; cyc(150);
        check(err_cnt == 1, "R9 edge on cmp2 match", err_cnt, 1);
        check(rx_q.size() == 0, "R9 no byte", rx_q.size(), 0);
        clear_obs();
        pulse_gap(62); pulse_gap(2); ser_in = 1'b0; cyc(150);
        check(err_cnt == 2, "R9 edge one past cmp2", err_cnt, 2);

        // R4 hunting threshold: spacing cmp1+1 never arms
        do_reset(); clear_obs(); cyc(3);
        for (int i = 0; i < 5; i++) pulse_gap(21);
        cyc(150);
        check(err_cnt == 0, "R4 spacing cmp1+1 not armed", err_cnt, 0);
        pulse_gap(2); cyc(150);
        check(err_cnt == 1, "R4 long idle arms", err_cnt, 1);
        // R4 spacing cmp1+2 arms
        do_reset(); clear_obs(); cyc(3);
        for (int i = 0; i < 3; i++) pulse_gap(21);
        pulse_gap(22); pulse_gap(2); cyc(150);
        check(err_cnt == 1, "R4 spacing cmp1+2 armed", err_cnt, 1);
        check(rx_q.size() == 0, "R4 no byte", rx_q.size(), 0);

        finish_run();
    end
endmodule